// File: doc/BRIEF.md
# Three-Multiplier Complex Multiplier

This block multiplies a complex data sample by a complex coefficient, such as an FFT twiddle factor, in fixed point. It uses three real multiplications instead of the four of the direct expansion. The data is written a + jb and the coefficient c + jd. The block forms three pre-sums: a+b, d−c and c+d. It then forms three products: k1 = c·(a+b), k2 = a·(d−c) and k3 = b·(c+d). Two post-adders give the result: real = k1 − k3 and imaginary = k1 + k2. That is three multipliers and five adders or subtractors in total. Each pre-sum is one bit wider than its operands, so it cannot overflow.

The coefficient is a signed fraction with one sign bit and COEF_W−1 fraction bits. The data is a signed integer of DATA_W bits. With the default widths of 18 bits, each operand fits one hardware multiplier. Each full-precision result is shifted right by COEF_W−1 bits with round-half-up. It is then clamped to the DATA_W-bit signed range, so an overflow never wraps.

The block accepts one operand set per clock and never stalls. The result appears exactly four clocks after the input strobe. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `cmplx_mul3`

## Requirements
- R1: With F = COEF_W−1 and a result that is in range, out_re equals floor((a·c − b·d + 2^(F−1)) / 2^F) and out_im equals floor((a·d + b·c + 2^(F−1)) / 2^F). All operands are two's-complement signed.
- R2: A full-precision result whose low F bits are exactly 2^(F−1) is rounded toward plus infinity. This holds for positive and negative values.
- R3: out_valid is high exactly four clock cycles after in_valid was high, and low four cycles after in_valid was low. Back-to-back inputs produce back-to-back outputs.
- R4: A rounded result above 2^(DATA_W−1)−1 is output as 2^(DATA_W−1)−1. A rounded result below −2^(DATA_W−1) is output as −2^(DATA_W−1).
- R5: When out_valid is low, out_re and out_im keep the value of the last valid result. Operands presented with in_valid low have no effect on the outputs.
- R6: While reset is asserted, and until the first valid result, out_valid is 0 and out_re and out_im are 0.
- R7: Each of the pre-sums a+b, d−c and c+d is registered at full width, one bit wider than its operands, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_a_re | input | DATA_W | Data real part a |
| in_a_im | input | DATA_W | Data imaginary part b |
| in_w_re | input | COEF_W | Coefficient real part c (signed fraction) |
| in_w_im | input | COEF_W | Coefficient imaginary part d (signed fraction) |
| out_valid | output | 1 | Result strobe, four cycles after in_valid |
| out_re | output | DATA_W | Rounded, saturated real part of the product |
| out_im | output | DATA_W | Rounded, saturated imaginary part of the product |

## Verification
The hardest cases to reach from the ports are operands at the extremes of their ranges. These are the only cases that saturate, and the only ones where the pre-sums need their extra bit. Exact rounding ties are also rare at full width. The bench therefore builds the block with 4-bit data and 4-bit coefficients and sweeps all 65536 combinations of the four operands. Every saturation corner and every tie is reached. Idle cycles carrying junk operands are interleaved with the sweep to exercise the hold behaviour and the valid timing.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
  localparam int DATA_W_DEF = 18;
  localparam int COEF_W_DEF = 18;
  localparam int LATENCY    = 4;
endpackage

// File: rtl/cmul3_rst_sync.sv
module cmul3_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
  parameter int DW = 18,
  parameter int CW = 18,
  localparam int PW = DW + 1,
  localparam int QW = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [CW-1:0] c_i,
  input  logic signed [CW-1:0] d_i,
  output logic signed [PW-1:0] ab_o,
  output logic signed [QW-1:0] dc_o,
  output logic signed [QW-1:0] cd_o,
  output logic signed [DW-1:0] a_o,
  output logic signed [DW-1:0] b_o,
  output logic signed [CW-1:0] c_o
);
  logic signed [PW-1:0] ab_nxt;
  logic signed [QW-1:0] dc_nxt;
  logic signed [QW-1:0] cd_nxt;

  always_comb begin
    ab_nxt = PW'(a_i) + PW'(b_i);
    dc_nxt = QW'(d_i) - QW'(c_i);
    cd_nxt = QW'(c_i) + QW'(d_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_o <= '0;
      dc_o <= '0;
      cd_o <= '0;
      a_o  <= '0;
      b_o  <= '0;
      c_o  <= '0;
    end else if (ce) begin
      ab_o <= ab_nxt;
      dc_o <= dc_nxt;
      cd_o <= cd_nxt;
      a_o  <= a_i;
      b_o  <= b_i;
      c_o  <= c_i;
    end
  end
endmodule

// File: rtl/cmul3_mulcore.sv
module cmul3_mulcore #(
  parameter int DW = 18,
  parameter int CW = 18,
  localparam int PW = DW + 1,
  localparam int QW = CW + 1,
  localparam int MW = DW + CW + 1,
  localparam int SW = MW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_mul,
  input  logic                 ce_add,
  input  logic signed [PW-1:0] ab_i,
  input  logic signed [QW-1:0] dc_i,
  input  logic signed [QW-1:0] cd_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [CW-1:0] c_i,
  output logic signed [SW-1:0] re_o,
  output logic signed [SW-1:0] im_o
);
  logic signed [MW-1:0] k1_q, k2_q, k3_q;
  logic signed [MW-1:0] k1_nxt, k2_nxt, k3_nxt;
  logic signed [SW-1:0] re_nxt, im_nxt;

  always_comb begin
    k1_nxt = MW'(c_i) * MW'(ab_i);
    k2_nxt = MW'(a_i) * MW'(dc_i);
    k3_nxt = MW'(b_i) * MW'(cd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k1_q <= '0;
      k2_q <= '0;
      k3_q <= '0;
    end else if (ce_mul) begin
      k1_q <= k1_nxt;
      k2_q <= k2_nxt;
      k3_q <= k3_nxt;
    end
  end

  always_comb begin
    re_nxt = SW'(k1_q) - SW'(k3_q);
    im_nxt = SW'(k1_q) + SW'(k2_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_o <= '0;
      im_o <= '0;
    end else if (ce_add) begin
      re_o <= re_nxt;
      im_o <= im_nxt;
    end
  end
endmodule

// File: rtl/cmul3_rndsat.sv
module cmul3_rndsat #(
  parameter int SW = 38,
  parameter int DW = 18,
  parameter int F  = 17,
  localparam int EW = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic signed [SW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [EW-1:0] HALF = EW'(1) <<< (F - 1);
  localparam logic signed [EW-1:0] MAXV = (EW'(1) <<< (DW - 1)) - EW'(1);
  localparam logic signed [EW-1:0] MINV = -MAXV - EW'(1);

  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] shr;
  logic signed [DW-1:0] y_nxt;

  always_comb begin
    ext = EW'(x_i) + HALF;
    shr = ext >>> F;
    if (shr > MAXV)
      y_nxt = MAXV[DW-1:0];
    else if (shr < MINV)
      y_nxt = MINV[DW-1:0];
    else
      y_nxt = shr[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      y_o <= '0;
    else if (ce)
      y_o <= y_nxt;
  end
endmodule

// File: rtl/cmplx_mul3.sv
module cmplx_mul3 #(
  parameter int DATA_W = cmul3_pkg::DATA_W_DEF,
  parameter int COEF_W = cmul3_pkg::COEF_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_a_re,
  input  logic signed [DATA_W-1:0] in_a_im,
  input  logic signed [COEF_W-1:0] in_w_re,
  input  logic signed [COEF_W-1:0] in_w_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);
  localparam int LAT  = cmul3_pkg::LATENCY;
  localparam int FRAC = COEF_W - 1;
  localparam int PW   = DATA_W + 1;
  localparam int QW   = COEF_W + 1;
  localparam int SW   = DATA_W + COEF_W + 2;

  logic rst_sync_n;
  logic [LAT:1] vld_q;
  logic [LAT:1] vld_nxt;
  logic vld_s1, vld_s2, vld_s3;

  logic signed [PW-1:0]     pre_ab;
  logic signed [QW-1:0]     pre_dc, pre_cd;
  logic signed [DATA_W-1:0] dly_a, dly_b;
  logic signed [COEF_W-1:0] dly_c;
  logic signed [SW-1:0]     post_re, post_im;
  logic signed [SW-1:0]     post_lane [2];
  logic signed [DATA_W-1:0] res_lane  [2];

  cmul3_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    vld_nxt[1] = in_valid;
    for (int s = 2; s <= LAT; s++) vld_nxt[s] = vld_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= '0;
    else             vld_q <= vld_nxt;
  end

  assign vld_s1 = vld_q[1];
  assign vld_s2 = vld_q[2];
  assign vld_s3 = vld_q[3];

  cmul3_preadd #(.DW(DATA_W), .CW(COEF_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ce    (in_valid),
    .a_i   (in_a_re),
    .b_i   (in_a_im),
    .c_i   (in_w_re),
    .d_i   (in_w_im),
    .ab_o  (pre_ab),
    .dc_o  (pre_dc),
    .cd_o  (pre_cd),
    .a_o   (dly_a),
    .b_o   (dly_b),
    .c_o   (dly_c)
  );

  cmul3_mulcore #(.DW(DATA_W), .CW(COEF_W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ce_mul (vld_s1),
    .ce_add (vld_s2),
    .ab_i   (pre_ab),
    .dc_i   (pre_dc),
    .cd_i   (pre_cd),
    .a_i    (dly_a),
    .b_i    (dly_b),
    .c_i    (dly_c),
    .re_o   (post_re),
    .im_o   (post_im)
  );

  assign post_lane[0] = post_re;
  assign post_lane[1] = post_im;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    cmul3_rndsat #(.SW(SW), .DW(DATA_W), .F(FRAC)) u_rs (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ce    (vld_s3),
      .x_i   (post_lane[g]),
      .y_o   (res_lane[g])
    );
  end

  assign out_valid = vld_q[LAT];
  assign out_re    = res_lane[0];
  assign out_im    = res_lane[1];
endmodule

// File: rtl/cmul3_chk.sv
module cmul3_chk #(
  parameter int DW = 18,
  parameter int CW = 18,
  localparam int PW = DW + 1,
  localparam int SW = DW + CW + 2,
  localparam int F  = CW - 1
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_a_re,
  input logic signed [DW-1:0] in_a_im,
  input logic                 vld_s1,
  input logic signed [PW-1:0] pre_ab,
  input logic                 vld_s3,
  input logic signed [SW-1:0] post_re,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_re,
  input logic signed [DW-1:0] out_im
);
  localparam longint THI  = (64'sd1 <<< (DW - 1 + F)) - (64'sd1 <<< (F - 1));
  localparam longint TLO  = -(64'sd1 <<< (DW - 1 + F)) - (64'sd1 <<< (F - 1));
  localparam logic signed [DW-1:0] MAXO = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINO = {1'b1, {(DW-1){1'b0}}};

  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc >= 3'd1 && !out_valid) |-> ($stable(out_re) && $stable(out_im)));

  // R4
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_s3 && longint'(post_re) >= THI) |=> (out_re == MAXO));

  // R4
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vld_s3 && longint'(post_re) < TLO) |=> (out_re == MINO));

  // R7
  preadd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc >= 3'd1 && in_valid) |=> (pre_ab == PW'($past(in_a_re)) + PW'($past(in_a_im))));

  // R3
  s1_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc >= 3'd1) |-> (vld_s1 == $past(in_valid)));
endmodule

bind cmplx_mul3 cmul3_chk #(.DW(DATA_W), .CW(COEF_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_a_re    (in_a_re),
  .in_a_im    (in_a_im),
  .vld_s1     (vld_s1),
  .pre_ab     (pre_ab),
  .vld_s3     (vld_s3),
  .post_re    (post_re),
  .out_valid  (out_valid),
  .out_re     (out_re),
  .out_im     (out_im)
);

// File: tb/tb_cmplx_mul3.sv
module tb_cmplx_mul3;
  localparam int DW = 4;
  localparam int CW = 4;
  localparam int F  = CW - 1;
  localparam longint MAXO = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint MINO = -(64'sd1 <<< (DW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_a_re = '0, in_a_im = '0;
  logic signed [CW-1:0] in_w_re = '0, in_w_im = '0;
  logic out_valid;
  logic signed [DW-1:0] out_re, out_im;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit     sh_v  [4];
  longint sh_re [4];
  longint sh_im [4];
  bit     sh_tr [4];
  bit     sh_ti [4];
  bit     sh_sr [4];
  bit     sh_si [4];
  longint last_re = 0, last_im = 0;

  always #5 clk = ~clk;

  cmplx_mul3 #(.DATA_W(DW), .COEF_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a_re(in_a_re), .in_a_im(in_a_im), .in_w_re(in_w_re), .in_w_im(in_w_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic longint rnd_sat(input longint p, output bit tie, output bit sat);
    longint r;
    tie = ((p & ((64'sd1 <<< F) - 1)) == (64'sd1 <<< (F - 1)));
    r = (p + (64'sd1 <<< (F - 1))) >>> F;
    sat = (r > MAXO) || (r < MINO);
    if (r > MAXO) r = MAXO;
    if (r < MINO) r = MINO;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag(input bit t, input bit s);
    if (s) return "R4";
    if (t) return "R2";
    return "R1";
  endfunction

  task automatic step(input bit v, input logic signed [DW-1:0] a, input logic signed [DW-1:0] b,
                      input logic signed [CW-1:0] c, input logic signed [CW-1:0] d);
    longint pr, pi;
    @(negedge clk);
    if (sh_v[3]) begin
      chk(out_valid == 1'b1, "R3", longint'(out_valid), 1);
      chk(longint'(out_re) == sh_re[3], tag(sh_tr[3], sh_sr[3]), longint'(out_re), sh_re[3]);
      chk(longint'(out_im) == sh_im[3], tag(sh_ti[3], sh_si[3]), longint'(out_im), sh_im[3]);
      last_re = sh_re[3];
      last_im = sh_im[3];
    end else begin
      chk(out_valid == 1'b0, "R3", longint'(out_valid), 0);
      chk(longint'(out_re) == last_re && longint'(out_im) == last_im, "R5",
          longint'(out_re), last_re);
    end
    for (int k = 3; k > 0; k--) begin
      sh_v[k] = sh_v[k-1]; sh_re[k] = sh_re[k-1]; sh_im[k] = sh_im[k-1];
      sh_tr[k] = sh_tr[k-1]; sh_ti[k] = sh_ti[k-1]; sh_sr[k] = sh_sr[k-1]; sh_si[k] = sh_si[k-1];
    end
    pr = longint'(a) * longint'(c) - longint'(b) * longint'(d);
    pi = longint'(a) * longint'(d) + longint'(b) * longint'(c);
    sh_v[0]  = v;
    sh_re[0] = rnd_sat(pr, sh_tr[0], sh_sr[0]);
    sh_im[0] = rnd_sat(pi, sh_ti[0], sh_si[0]);
    in_valid = v;
    in_a_re = a; in_a_im = b; in_w_re = c; in_w_im = d;
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      sh_v[k] = 1'b0; sh_re[k] = 0; sh_im[k] = 0;
      sh_tr[k] = 1'b0; sh_ti[k] = 1'b0; sh_sr[k] = 1'b0; sh_si[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R6: outputs during reset
    chk(out_valid == 1'b0, "R6", longint'(out_valid), 0);
    chk(out_re == '0 && out_im == '0, "R6", longint'(out_re), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R6: still idle after release
    chk(out_valid == 1'b0 && out_re == '0 && out_im == '0, "R6", longint'(out_re), 0);
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] pat;
      pat = 16'(i);
      if ((i % 7) == 3)
        step(1'b0, ~pat[3:0], pat[7:4], ~pat[11:8], pat[15:12]);
      step(1'b1, pat[3:0], pat[7:4], pat[11:8], pat[15:12]);
    end
    for (int j = 0; j < 6; j++) step(1'b0, 4'sd7, -4'sd8, 4'sd7, -4'sd8);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule